// File: doc/BRIEF.md
# Depth-Cascade Hit Result Arbiter

A lookup table can be built from several search devices stacked in depth, all sharing one result bus. For every search, each device must decide by itself whether it may drive that bus. This block makes that decision for one device. It takes three inputs: the device's own match outcome and match address, a 7-bit bus of hit indications from higher-priority devices in the same group, and a 3-bit bus of hit indications from higher-priority groups. When a search strobe arrives, the block reduces both upstream buses by OR and picks one of five states. The outputs follow from that state on the next cycle.

The result bus has three parts: a 22-bit address, a status-valid line and a hit-flag line. The tri-state drivers of the bus are modelled by separate drive-enable outputs. A device whose higher neighbours have hit keeps its drivers off. It passes the hit on downward on two replicated hit-out buses, so that every device below it is also suppressed. One configuration input marks the last device of the cascade. On a global miss that device drives the bus anyway, with status-valid high and the hit flag low, so the bus never floats at the end of a search.

State names are `ST_IDLE`, `ST_YIELD`, `ST_DRIVE_HIT`, `ST_DRIVE_MISS` and `ST_SILENT`. Every clock edge takes one of the following transitions, from any state:
- no strobe leads to `ST_IDLE`;
- strobe with any upstream hit leads to `ST_YIELD`;
- strobe with a local hit and no upstream hit leads to `ST_DRIVE_HIT`;
- strobe with no hit anywhere and the last-device input set leads to `ST_DRIVE_MISS`;
- strobe with no hit anywhere and the last-device input clear leads to `ST_SILENT`.

Top module: `cascade_hit_arbiter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the state is `ST_IDLE`. In that state both drive enables are 0, status-valid and hit flag are 0, and every hit-out bit is 0.
- R2: Any single set bit of `up_grp_hit` counts as an upstream hit, whatever the local match result or the last-device input.
- R3: Any single set bit of `up_blk_hit` counts as an upstream hit, whatever the local match result or the last-device input.
- R4: On the cycle after a strobe that sees an upstream hit, `res_addr_oe` and `res_stat_oe` are 0, `res_addr` is 0, and every hit-out bit is 1.
- R5: On the cycle after a strobe with `loc_hit`=1 and no upstream hit, both enables are 1 and `res_addr` equals the `loc_addr` sampled with the strobe. Status-valid, hit flag and every hit-out bit are 1.
- R6: On the cycle after a strobe with no hit anywhere and `cfg_last`=1, both enables are 1, status-valid is 1, hit flag is 0, `res_addr` is 0 and the hit-out bits are 0.
- R7: On the cycle after a strobe with no hit anywhere and `cfg_last`=0, both enables are 0 and every hit-out bit is 0.
- R8: Within `dn_grp_hit` all bits are equal, and within `dn_blk_hit` all bits are equal. The two buses carry the same value.
- R9: On the cycle after a clock edge with `srch_vld`=0, the block is back in `ST_IDLE` with every output 0, whatever the other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| srch_vld | input | 1 | Search result strobe for this cycle |
| loc_hit | input | 1 | Local match outcome |
| loc_addr | input | 22 | Local match address |
| up_grp_hit | input | 7 | Hit indications from higher devices in the same group |
| up_blk_hit | input | 3 | Hit indications from higher groups |
| cfg_last | input | 1 | Marks this device as last in the cascade |
| res_addr | output | 22 | Result address value (0 when not driven) |
| res_addr_oe | output | 1 | Drive enable for the result address |
| res_valid | output | 1 | Status-valid value |
| res_flag | output | 1 | Hit flag value |
| res_stat_oe | output | 1 | Drive enable for status-valid and hit flag |
| dn_grp_hit | output | 2 | Replicated hit-out to lower devices in the group |
| dn_blk_hit | output | 3 | Replicated hit-out to lower groups |

## Verification
The hardest case to reach is a single upstream hit bit that arrives together with a local hit on a device marked last. Here suppression must win over both the local drive and the default-miss drive. Uniform random buses almost never produce a lone set bit next to these conditions. The stimulus therefore leaves each upstream bus all-zero half the time and otherwise sets a single random bit. Directed sweeps also walk one set bit across every position of both buses, with the local hit and last-device inputs both set.

// File: rtl/cha_pkg.sv
package cha_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_YIELD,
        ST_DRIVE_HIT,
        ST_DRIVE_MISS,
        ST_SILENT
    } arb_state_e;
endpackage

// File: rtl/cha_or_reduce.sv
module cha_or_reduce #(
    parameter int W = 7
) (
    input  logic [W-1:0] bits_i,
    output logic         any_o
);
    logic [W:0] acc;
    assign acc[0] = 1'b0;
    for (genvar i = 0; i < W; i++) begin : g_or
        assign acc[i+1] = acc[i] | bits_i[i];
    end
    assign any_o = acc[W];
endmodule

// File: rtl/cha_fanout.sv
module cha_fanout #(
    parameter int W = 2
) (
    input  logic         src_i,
    output logic [W-1:0] dst_o
);
    for (genvar i = 0; i < W; i++) begin : g_rep
        assign dst_o[i] = src_i;
    end
endmodule

// File: rtl/cha_fsm.sv
module cha_fsm
    import cha_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srch_vld,
    input  logic              loc_hit,
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic              up_any,
    input  logic              cfg_last,
    output logic [ADDR_W-1:0] addr_o,
    output logic              drive_o,
    output logic              valid_o,
    output logic              flag_o,
    output logic              pass_o
);
    arb_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;

    always_comb begin
        if (!srch_vld)      state_d = ST_IDLE;
        else if (up_any)    state_d = ST_YIELD;
        else if (loc_hit)   state_d = ST_DRIVE_HIT;
        else if (cfg_last)  state_d = ST_DRIVE_MISS;
        else                state_d = ST_SILENT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= (state_d == ST_DRIVE_HIT) ? loc_addr : '0;
        end
    end

    always_comb begin
        addr_o  = '0;
        drive_o = 1'b0;
        valid_o = 1'b0;
        flag_o  = 1'b0;
        pass_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_SILENT: ;
            ST_YIELD:  pass_o = 1'b1;
            ST_DRIVE_HIT: begin
                addr_o  = addr_q;
                drive_o = 1'b1;
                valid_o = 1'b1;
                flag_o  = 1'b1;
                pass_o  = 1'b1;
            end
            ST_DRIVE_MISS: begin
                drive_o = 1'b1;
                valid_o = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cascade_hit_arbiter.sv
module cascade_hit_arbiter #(
    parameter int ADDR_W = 22,
    parameter int UPG_W  = 7,
    parameter int UPB_W  = 3,
    parameter int DNG_W  = 2,
    parameter int DNB_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srch_vld,
    input  logic              loc_hit,
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic [UPG_W-1:0]  up_grp_hit,
    input  logic [UPB_W-1:0]  up_blk_hit,
    input  logic              cfg_last,
    output logic [ADDR_W-1:0] res_addr,
    output logic              res_addr_oe,
    output logic              res_valid,
    output logic              res_flag,
    output logic              res_stat_oe,
    output logic [DNG_W-1:0]  dn_grp_hit,
    output logic [DNB_W-1:0]  dn_blk_hit
);
    logic grp_any, blk_any, drive, pass;

    cha_or_reduce #(.W(UPG_W)) u_grp_or (.bits_i(up_grp_hit), .any_o(grp_any));
    cha_or_reduce #(.W(UPB_W)) u_blk_or (.bits_i(up_blk_hit), .any_o(blk_any));

    cha_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .srch_vld (srch_vld),
        .loc_hit  (loc_hit),
        .loc_addr (loc_addr),
        .up_any   (grp_any | blk_any),
        .cfg_last (cfg_last),
        .addr_o   (res_addr),
        .drive_o  (drive),
        .valid_o  (res_valid),
        .flag_o   (res_flag),
        .pass_o   (pass)
    );

    assign res_addr_oe = drive;
    assign res_stat_oe = drive;

    cha_fanout #(.W(DNG_W)) u_grp_rep (.src_i(pass), .dst_o(dn_grp_hit));
    cha_fanout #(.W(DNB_W)) u_blk_rep (.src_i(pass), .dst_o(dn_blk_hit));
endmodule

// File: rtl/cascade_hit_arbiter_chk.sv
module cascade_hit_arbiter_chk #(
    parameter int ADDR_W = 22,
    parameter int UPG_W  = 7,
    parameter int UPB_W  = 3,
    parameter int DNG_W  = 2,
    parameter int DNB_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              srch_vld,
    input logic              loc_hit,
    input logic [ADDR_W-1:0] loc_addr,
    input logic [UPG_W-1:0]  up_grp_hit,
    input logic [UPB_W-1:0]  up_blk_hit,
    input logic              cfg_last,
    input logic [ADDR_W-1:0] res_addr,
    input logic              res_addr_oe,
    input logic              res_valid,
    input logic              res_flag,
    input logic              res_stat_oe,
    input logic [DNG_W-1:0]  dn_grp_hit,
    input logic [DNB_W-1:0]  dn_blk_hit
);
    p_grp_suppress_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_vld && (|up_grp_hit)) |=> (!res_addr_oe && !res_stat_oe && (&dn_grp_hit)));

    p_blk_suppress_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_vld && (|up_blk_hit)) |=> (!res_addr_oe && !res_stat_oe && (&dn_blk_hit)));

    p_yield_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_vld && ((|up_grp_hit) || (|up_blk_hit))) |=> (res_addr == '0 && !res_valid));

    p_hit_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_vld && loc_hit && !(|up_grp_hit) && !(|up_blk_hit))
        |=> (res_addr_oe && res_flag && res_valid && res_addr == $past(loc_addr)));

    p_default_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_vld && !loc_hit && cfg_last && !(|up_grp_hit) && !(|up_blk_hit))
        |=> (res_stat_oe && res_valid && !res_flag && res_addr == '0));

    p_silent_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_vld && !loc_hit && !cfg_last && !(|up_grp_hit) && !(|up_blk_hit))
        |=> (!res_addr_oe && !res_stat_oe && !(|dn_grp_hit) && !(|dn_blk_hit)));

    p_replica_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (($countones(dn_grp_hit) == 0 && $countones(dn_blk_hit) == 0) ||
         ((&dn_grp_hit) && (&dn_blk_hit))));

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_vld |=> (!res_addr_oe && !res_stat_oe && !res_valid && !(|dn_grp_hit)));
endmodule

bind cascade_hit_arbiter cascade_hit_arbiter_chk #(
    .ADDR_W(ADDR_W), .UPG_W(UPG_W), .UPB_W(UPB_W), .DNG_W(DNG_W), .DNB_W(DNB_W)
) u_chk (.*);

// File: tb/tb_cascade_hit_arbiter.sv
module tb_cascade_hit_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 22;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          srch_vld = 1'b0;
    logic          loc_hit = 1'b0;
    logic [AW-1:0] loc_addr = '0;
    logic [6:0]    up_grp_hit = '0;
    logic [2:0]    up_blk_hit = '0;
    logic          cfg_last = 1'b0;
    logic [AW-1:0] res_addr;
    logic          res_addr_oe, res_valid, res_flag, res_stat_oe;
    logic [1:0]    dn_grp_hit;
    logic [2:0]    dn_blk_hit;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cascade_hit_arbiter dut (
        .clk(clk), .rst_n(rst_n), .srch_vld(srch_vld), .loc_hit(loc_hit),
        .loc_addr(loc_addr), .up_grp_hit(up_grp_hit), .up_blk_hit(up_blk_hit),
        .cfg_last(cfg_last), .res_addr(res_addr), .res_addr_oe(res_addr_oe),
        .res_valid(res_valid), .res_flag(res_flag), .res_stat_oe(res_stat_oe),
        .dn_grp_hit(dn_grp_hit), .dn_blk_hit(dn_blk_hit)
    );

    // packed layout: addr, addr_oe, valid, flag, stat_oe, dn_grp, dn_blk
    function automatic logic [AW+8:0] expect_out(input logic v, input logic lh,
            input logic [AW-1:0] la, input logic [6:0] ug, input logic [2:0] ub,
            input logic last);
        if (!v)                  return '0;                                  // R9
        if ((|ug) || (|ub))      return {{AW{1'b0}}, 4'b0000, 5'b11111};     // R2 R3 R4
        if (lh)                  return {la, 4'b1111, 5'b11111};             // R5
        if (last)                return {{AW{1'b0}}, 4'b1101, 5'b00000};     // R6
        return '0;                                                           // R7
    endfunction

    function automatic string tag_of(input logic v, input logic lh,
            input logic [6:0] ug, input logic [2:0] ub, input logic last);
        if (!v)        return "R9";
        if (|ug)       return "R2/R4/R8";
        if (|ub)       return "R3/R4/R8";
        if (lh)        return "R5/R8";
        if (last)      return "R6";
        return "R7";
    endfunction

    function automatic logic [AW+8:0] actual_out();
        return {res_addr, res_addr_oe, res_valid, res_flag, res_stat_oe, dn_grp_hit, dn_blk_hit};
    endfunction

    task automatic compare(input string tag, input logic [AW+8:0] exp);
        n_chk++;
        if (actual_out() !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, actual_out(), exp);
        end
    endtask

    task automatic step(input logic v, input logic lh, input logic [AW-1:0] la,
            input logic [6:0] ug, input logic [2:0] ub, input logic last);
        srch_vld = v; loc_hit = lh; loc_addr = la;
        up_grp_hit = ug; up_blk_hit = ub; cfg_last = last;
        @(posedge clk);
        @(negedge clk);
        compare(tag_of(v, lh, ug, ub, last), expect_out(v, lh, la, ug, ub, last));
    endtask

    function automatic logic [6:0] sparse7();
        if ($urandom_range(1, 0) == 0) return '0;
        return 7'(1) << $urandom_range(6, 0);
    endfunction

    function automatic logic [2:0] sparse3();
        if ($urandom_range(1, 0) == 0) return '0;
        return 3'(1) << $urandom_range(2, 0);
    endfunction

    initial begin
        void'($urandom(32'd4711));
        // R1: reset state
        @(negedge clk);
        compare("R1", '0);
        srch_vld = 1'b1; loc_hit = 1'b1; loc_addr = 22'h2ABCDE; cfg_last = 1'b1;
        @(negedge clk);
        compare("R1", '0);
        srch_vld = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1", '0);

        // directed corners
        step(1, 1, 22'h3FFFFF, 7'h00, 3'h0, 0);   // R5 all-ones address
        step(1, 1, 22'h000001, 7'h00, 3'h0, 1);   // R5 last device with local hit
        step(1, 0, 22'h155555, 7'h00, 3'h0, 1);   // R6
        step(1, 0, 22'h155555, 7'h00, 3'h0, 0);   // R7
        step(0, 1, 22'h123456, 7'h7F, 3'h7, 1);   // R9
        for (int i = 0; i < 7; i++) step(1, 1, 22'h0ABCDE, 7'(1) << i, 3'h0, 1); // R2
        for (int i = 0; i < 3; i++) step(1, 1, 22'h0ABCDE, 7'h00, 3'(1) << i, 1); // R3
        step(1, 0, 22'h0, 7'h40, 3'h4, 0);         // R4

        // constrained random
        for (int n = 0; n < 2000; n++) begin
            step(1'($urandom_range(3, 0) != 0), 1'($urandom_range(1, 0)),
                 AW'($urandom()), sparse7(), sparse3(), 1'($urandom_range(1, 0)));
        end

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule